// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a register of parameterized width that, on each rising clock edge, either keeps its contents, shifts by one place toward the least significant bit, shifts by one place toward the most significant bit, or takes a whole word from a parallel bus. A 2-bit mode input selects the operation. An active-low clear empties the register at once, without waiting for the clock, and overrides every mode.

Each shift direction has its own serial input. The right-shift input fills the most significant stage, and the left-shift input fills the least significant stage. Both end stages are also driven out on separate pins, so several units can be chained. The same block can serve as a serial-to-parallel receiver, a parallel-to-serial transmitter or a ring counter. A ring counter is formed by returning the outgoing end bit to the incoming serial pin outside the block.

Top module: `univ_shreg`

## Requirements
- R1: With mode 2'b00, the word q keeps its value across a rising clock edge.
- R2: With mode 2'b01 (shift right), after a rising edge each bit q[i] takes the former q[i+1], and q[W-1] takes ser_r.
- R3: With mode 2'b10 (shift left), after a rising edge each bit q[i] takes the former q[i-1], and q[0] takes ser_l.
- R4: With mode 2'b11, after a rising edge q equals par_in.
- R5: While clr_n is low, q reads all zeros without any clock edge, whatever the mode and data inputs are.
- R6: When clr_n rises, q stays zero until the next rising clock edge, and that edge applies the selected mode as usual.
- R7: msb_out always equals q[W-1], and lsb_out always equals q[0].
- R8: In mode 2'b10 with msb_out fed back into ser_l, a single 1 moves up one place per clock and is back at its starting bit after W clocks.
- R9: After W right shifts, the serial bits presented on ser_r sit in q with the first bit sent in q[0] and the last bit sent in q[W-1].
- R10: After a parallel load followed by right shifts, lsb_out presents the loaded word least significant bit first, one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| ser_r | input | 1 | Serial bit entering the MSB on a right shift |
| ser_l | input | 1 | Serial bit entering the LSB on a left shift |
| par_in | input | W | Parallel load word |
| q | output | W | Register contents |
| msb_out | output | 1 | Most significant stage, for chaining |
| lsb_out | output | 1 | Least significant stage, for chaining |

## Verification
Hold, shift and load results appear one rising edge after the inputs are applied. The bench therefore drives inputs on a falling edge and compares q and both end pins at the next falling edge, against a model it steps once per clock. A clear takes effect within the same clock phase, so the bench checks for zero one time unit after it pulls clr_n low while the clock is low. On release, the bench first confirms that q is still zero before the next edge, and then checks the first edge after release as an ordinary step. Ring, serial-in and serial-out checks chain these one-edge steps and compare the word after every clock.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } usr_mode_e;

  typedef struct packed {
    logic load;
    logic left;
    logic right;
    logic keep;
  } usr_sel_t;

  // One-hot select vector for a given mode code.
  function automatic usr_sel_t usr_decode(input logic [1:0] code);
    usr_sel_t s;
    s = '0;
    unique case (usr_mode_e'(code))
      MODE_KEEP:  s.keep  = 1'b1;
      MODE_RIGHT: s.right = 1'b1;
      MODE_LEFT:  s.left  = 1'b1;
      MODE_LOAD:  s.load  = 1'b1;
      default:    s.keep  = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] mode,
  output logic       sel_keep,
  output logic       sel_right,
  output logic       sel_left,
  output logic       sel_load
);
  usr_sel_t sel;

  always_comb sel = usr_decode(mode);

  assign sel_keep  = sel.keep;
  assign sel_right = sel.right;
  assign sel_left  = sel.left;
  assign sel_load  = sel.load;
endmodule

// File: rtl/usr_cell.sv
module usr_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic sel_keep,
  input  logic sel_right,
  input  logic sel_left,
  input  logic sel_load,
  input  logic from_upper,
  input  logic from_lower,
  input  logic par_bit,
  output logic q_bit
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q_bit <= 1'b0;
    end else begin
      unique case ({sel_load, sel_left, sel_right, sel_keep})
        4'b0001: q_bit <= q_bit;
        4'b0010: q_bit <= from_upper;
        4'b0100: q_bit <= from_lower;
        4'b1000: q_bit <= par_bit;
        default: q_bit <= q_bit;
      endcase
    end
  end
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_r,
  input  logic         ser_l,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         msb_out,
  output logic         lsb_out
);
  localparam int MSB = W - 1;

  logic do_keep, do_right, do_left, do_load;
  logic [W-1:0] upper_nb;
  logic [W-1:0] lower_nb;

  usr_mode_decode u_dec (
    .mode      (mode),
    .sel_keep  (do_keep),
    .sel_right (do_right),
    .sel_left  (do_left),
    .sel_load  (do_load)
  );

  // Value each stage receives from above (right shift) and below (left shift).
  assign upper_nb = {ser_r, q[MSB:1]};
  assign lower_nb = {q[MSB-1:0], ser_l};

  for (genvar i = 0; i < W; i++) begin : g_stage
    usr_cell u_cell (
      .clk        (clk),
      .clr_n      (clr_n),
      .sel_keep   (do_keep),
      .sel_right  (do_right),
      .sel_left   (do_left),
      .sel_load   (do_load),
      .from_upper (upper_nb[i]),
      .from_lower (lower_nb[i]),
      .par_bit    (par_in[i]),
      .q_bit      (q[i])
    );
  end

  assign msb_out = q[MSB];
  assign lsb_out = q[0];
endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   mode,
  input logic         ser_r,
  input logic         ser_l,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q,
  input logic         msb_out,
  input logic         lsb_out,
  input logic         do_keep,
  input logic         do_right,
  input logic         do_left,
  input logic         do_load
);
  p_keep_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> $stable(q));

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!clr_n)
    $countones({do_keep, do_right, do_left, do_load}) == 1);

  p_right_r2: assert property (@(posedge clk) disable iff (!clr_n)
    do_right |=> q == {$past(ser_r), $past(q[W-1:1])});

  p_left_r3: assert property (@(posedge clk) disable iff (!clr_n)
    do_left |=> q == {$past(q[W-2:0]), $past(ser_l)});

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    do_load |=> q == $past(par_in));

  p_clear_r5: assert property (@(posedge clk)
    !clr_n |-> q == '0);

  p_release_r6: assert property (@(posedge clk)
    (!clr_n) |=> ($past(q) == '0));

  always_comb begin
    if (clr_n) begin
      p_ends_r7: assert (msb_out == q[W-1] && lsb_out == q[0]);
    end
  end
endmodule

bind univ_shreg usr_checker #(.W(W)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .mode     (mode),
  .ser_r    (ser_r),
  .ser_l    (ser_l),
  .par_in   (par_in),
  .q        (q),
  .msb_out  (msb_out),
  .lsb_out  (lsb_out),
  .do_keep  (do_keep),
  .do_right (do_right),
  .do_left  (do_left),
  .do_load  (do_load)
);

// File: tb/univ_shreg_tb.sv
module univ_shreg_tb;
  localparam int W     = 4;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic         ser_r;
  logic         sl_reg;
  logic         ring_en;
  logic         ser_l;
  logic [W-1:0] par_in;
  logic [W-1:0] q;
  logic         msb_out, lsb_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] exp_q;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign ser_l = ring_en ? msb_out : sl_reg;

  univ_shreg #(.W(W)) u_dut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_r(ser_r), .ser_l(ser_l),
    .par_in(par_in), .q(q), .msb_out(msb_out), .lsb_out(lsb_out)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic [1:0] m,
                                            input logic sr, input logic sl,
                                            input logic [W-1:0] p);
    logic [W-1:0] r;
    r = cur;
    if (m == 2'b01) begin
      r = cur >> 1;
      r[W-1] = sr;
    end else if (m == 2'b10) begin
      r = cur << 1;
      r[0] = sl;
    end else if (m == 2'b11) begin
      r = p;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ends(input string req);
    check(req, {{(W-1){1'b0}}, msb_out}, {{(W-1){1'b0}}, exp_q[W-1]});
    check(req, {{(W-1){1'b0}}, lsb_out}, {{(W-1){1'b0}}, exp_q[0]});
  endtask

  // Called just after a falling edge: apply inputs, run one rising edge, check at next falling edge.
  task automatic step(input string req, input logic [1:0] m, input logic sr,
                      input logic sl, input logic [W-1:0] p);
    logic sl_eff;
    mode = m; ser_r = sr; sl_reg = sl; par_in = p;
    sl_eff = ring_en ? exp_q[W-1] : sl;
    exp_q = ref_next(exp_q, m, sr, sl_eff, p);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(req, q, exp_q);
    check_ends("R7");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] bits;
    void'($urandom(32'd2024));
    clr_n = 1'b0; mode = 2'b11; ser_r = 1'b1; sl_reg = 1'b1; ring_en = 1'b0;
    par_in = '1; exp_q = '0;
    #2;
    check("R5 reset", q, '0);
    @(negedge clk); @(negedge clk);
    #1;
    check("R5 clock during clear", q, '0);
    clr_n = 1'b1;
    #1;
    check("R6 after release", q, '0);
    step("R6 first edge load", 2'b11, 1'b0, 1'b0, 4'b1010);

    step("R1 hold", 2'b00, 1'b1, 1'b1, 4'b0101);
    step("R1 hold", 2'b00, 1'b0, 1'b0, 4'b1111);
    step("R2 shift right", 2'b01, 1'b1, 1'b0, 4'b0000);
    step("R2 shift right", 2'b01, 1'b0, 1'b1, 4'b0000);
    step("R3 shift left", 2'b10, 1'b0, 1'b1, 4'b0000);
    step("R3 shift left", 2'b10, 1'b1, 1'b0, 4'b0000);
    step("R4 load", 2'b11, 1'b0, 1'b0, 4'b0110);

    // R9: serial in, parallel out
    bits = 4'b1101;
    for (int i = 0; i < W; i++) step("R9 serial in", 2'b01, bits[i], 1'b0, 4'b0000);
    check("R9 assembled word", q, bits);

    // R10: parallel in, serial out LSB first
    step("R10 load", 2'b11, 1'b0, 1'b0, 4'b1011);
    for (int i = 0; i < W; i++) begin
      check("R10 serial out", {{(W-1){1'b0}}, lsb_out}, {{(W-1){1'b0}}, bits[0] ^ bits[0] ^ (4'b1011 >> i) & 1'b1});
      step("R10 shift", 2'b01, 1'b0, 1'b0, 4'b0000);
    end

    // R8: ring counter via left shift with MSB fed back
    step("R8 seed", 2'b11, 1'b0, 1'b0, 4'b0001);
    ring_en = 1'b1;
    for (int i = 1; i <= W; i++) begin
      step("R8 ring", 2'b10, 1'b0, 1'b0, 4'b0000);
      check("R8 position", q, 4'b0001 << (i % W));
    end
    ring_en = 1'b0;

    // R5: clear mid-run, with shifting mode active
    step("R4 load", 2'b11, 1'b0, 1'b0, 4'b1111);
    mode = 2'b10; sl_reg = 1'b1;
    clr_n = 1'b0;
    #1;
    check("R5 async clear", q, '0);
    exp_q = '0;
    @(negedge clk);
    clr_n = 1'b1;
    #1;
    check("R6 release holds zero", q, '0);
    step("R6 first edge shift left", 2'b10, 1'b0, 1'b1, 4'b0000);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      case (m)
        2'b00: step("R1 random", m, 1'($urandom), 1'($urandom), W'($urandom));
        2'b01: step("R2 random", m, 1'($urandom), 1'($urandom), W'($urandom));
        2'b10: step("R3 random", m, 1'($urandom), 1'($urandom), W'($urandom));
        default: step("R4 random", m, 1'($urandom), 1'($urandom), W'($urandom));
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule